// File: doc/BRIEF.md
# Dual-Port RAM with Collision Arbitration

A synchronous dual-port memory of 4096 words, 9 bits each by default. Two independent ports, left and right, each have their own address, active-low chip enable, read/write select, active-low output enable and data lines. Either port may read or write any location in any cycle. The read data path is registered, and the bus output is three-state. That output is modelled as a data vector plus a drive-enable, and the data vector is forced to zero while the port is not driving.

An arbiter watches both ports. When both are enabled on the same address, it picks one winner. The other port gets a busy flag one cycle later, which is when its read data also appears. A write from the losing port is dropped.

A mode input sets master or slave behaviour. In master mode the device arbitrates and drives both busy outputs. In slave mode it does no arbitration of its own: it takes busy from two inputs, uses them to gate its writes, and leaves its own busy outputs released high. This lets several devices placed side by side for a wider word share one master's decision over a wired-OR busy line.

Top module: `dpram_arb_top`

## Requirements
- R1: A write stores its data when the port's chip enable is low, its read/write select is low (write), and the port is not blocked. A later read of that address with chip enable low, select high (read) and output enable low puts that data on the port's read data one cycle after the access.
- R2: The drive-enable output is high in the cycle after an access only if that access was a read with chip enable low and output enable low. Otherwise it is low, and the read data output is zero.
- R3: A busy output is asserted (low) only in the cycle after both chip enables were low and both addresses were equal, and only in master mode. Equal addresses with one chip enable high raise no busy.
- R4: In master mode, when a collision starts in a cycle where neither port accessed that address in the previous cycle, the left port wins and the right busy output goes low. The two busy outputs are never low together.
- R5: If exactly one port accessed the colliding address in the previous cycle, that port wins. If both did, the winner of the previous cycle keeps priority.
- R6: A write from the losing port leaves memory unchanged.
- R7: A read from the losing port still returns the stored word in the same cycle its busy flag is shown.
- R8: A busy output returns high in the cycle after the ports' addresses differ or either chip enable is high.
- R9: In slave mode both busy outputs stay high. A write is suppressed when that port's busy input is low, and the busy inputs have no effect in master mode. If both ports write one location in the same cycle with neither busy input low, the right port's data is kept.
- R10: When the winning port writes an address that the other port reads in the same cycle, the reader gets the old word. A read in the next cycle returns the new word.
- R11: During and right after reset, both busy outputs are high and both drive-enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| masterMode | input | 1 | 1 = arbitrate internally, 0 = take busy from the inputs |
| ceLN | input | 1 | Left chip enable, active low |
| rwLN | input | 1 | Left select, 1 = read, 0 = write |
| oeLN | input | 1 | Left output enable, active low |
| addrL | input | ADDR_W | Left address |
| wrDataL | input | DATA_W | Left write data |
| rdDataL | output | DATA_W | Left read data, zero when not driving |
| rdDriveL | output | 1 | Left bus drive-enable |
| busyLN | output | 1 | Left busy, active low, released high |
| busyInLN | input | 1 | Left busy from an external master, active low |
| ceRN | input | 1 | Right chip enable, active low |
| rwRN | input | 1 | Right select, 1 = read, 0 = write |
| oeRN | input | 1 | Right output enable, active low |
| addrR | input | ADDR_W | Right address |
| wrDataR | input | DATA_W | Right write data |
| rdDataR | output | DATA_W | Right read data, zero when not driving |
| rdDriveR | output | 1 | Right bus drive-enable |
| busyRN | output | 1 | Right busy, active low, released high |
| busyInRN | input | 1 | Right busy from an external master, active low |

## Verification
The assertions assume that the mode input and every port input are stable across each rising edge and are never X once reset is released. They also assume the busy inputs are only meaningful in slave mode. The stimulus changes every input just after a rising edge and reads outputs one time unit later. It concentrates random addresses on a small set that was written during a fill phase, so collisions are frequent and every read has a known expected word. Mode changes happen only between stimulus segments, with an idle cycle before them.

// File: rtl/dpram_arb_pkg.sv
package dpram_arb_pkg;
  localparam int NUM_PORTS = 2;
  localparam int PORT_L = 0;
  localparam int PORT_R = 1;

  // strobes handed from arbitration control to the storage datapath
  typedef struct packed {
    logic [NUM_PORTS-1:0] wrEn;
    logic [NUM_PORTS-1:0] rdEn;
    logic [NUM_PORTS-1:0] oeReq;
  } dpStrobes_t;
endpackage

// File: rtl/dpram_arb_ctrl.sv
module dpram_arb_ctrl
  import dpram_arb_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               masterMode,
  input  logic [NUM_PORTS-1:0]               ceN,
  input  logic [NUM_PORTS-1:0]               rwN,
  input  logic [NUM_PORTS-1:0]               oeN,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]   addr,
  input  logic [NUM_PORTS-1:0]               extBusyN,
  output dpStrobes_t                         strobes,
  output logic [NUM_PORTS-1:0]               busyN
);
  logic [NUM_PORTS-1:0]             prevEn;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] prevAddr;
  logic                             prevWinR;
  logic [NUM_PORTS-1:0]             held;
  logic [NUM_PORTS-1:0]             lose;
  logic [NUM_PORTS-1:0]             block;
  logic [NUM_PORTS-1:0]             busyQ;
  logic                             collide;
  logic                             winR;

  assign collide = ~ceN[PORT_L] & ~ceN[PORT_R] & (addr[PORT_L] == addr[PORT_R]);

  // a port "holds" the location when it accessed the same address last cycle
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hold
    assign held[p] = prevEn[p] & (prevAddr[p] == addr[p]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevEn[p]   <= 1'b0;
        prevAddr[p] <= '0;
      end else begin
        prevEn[p]   <= ~ceN[p];
        prevAddr[p] <= addr[p];
      end
    end
  end

  // right wins only through prior occupancy; fresh ties go left
  assign winR = collide & held[PORT_R] & (~held[PORT_L] | prevWinR);
  assign lose[PORT_L] = collide & winR;
  assign lose[PORT_R] = collide & ~winR;

  assign block = masterMode ? lose : ~extBusyN;

  always_comb begin
    strobes.wrEn  = ~ceN & ~rwN & ~block;
    strobes.rdEn  = ~ceN & rwN;
    strobes.oeReq = ~oeN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWinR <= 1'b0;
      busyQ    <= '0;
    end else begin
      prevWinR <= winR;
      busyQ    <= masterMode ? lose : '0;
    end
  end

  assign busyN = ~busyQ;
endmodule

// File: rtl/dpram_arb_datapath.sv
module dpram_arb_datapath
  import dpram_arb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  dpStrobes_t                         strobes,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]   addr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]   wrData,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]   rdData,
  output logic [NUM_PORTS-1:0]               rdDrive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // right write is applied last so it prevails on a shared location
  always_ff @(posedge clk) begin
    if (strobes.wrEn[PORT_L]) mem[addr[PORT_L]] <= wrData[PORT_L];
    if (strobes.wrEn[PORT_R]) mem[addr[PORT_R]] <= wrData[PORT_R];
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
    logic [DATA_W-1:0] rdQ;
    logic              driveQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdQ    <= '0;
        driveQ <= 1'b0;
      end else begin
        driveQ <= strobes.rdEn[p] & strobes.oeReq[p];
        if (strobes.rdEn[p]) rdQ <= mem[addr[p]];
      end
    end

    assign rdDrive[p] = driveQ;
    assign rdData[p]  = driveQ ? rdQ : '0;
  end
endmodule

// File: rtl/dpram_arb_top.sv
module dpram_arb_top
  import dpram_arb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              ceLN,
  input  logic              rwLN,
  input  logic              oeLN,
  input  logic [ADDR_W-1:0] addrL,
  input  logic [DATA_W-1:0] wrDataL,
  output logic [DATA_W-1:0] rdDataL,
  output logic              rdDriveL,
  output logic              busyLN,
  input  logic              busyInLN,
  input  logic              ceRN,
  input  logic              rwRN,
  input  logic              oeRN,
  input  logic [ADDR_W-1:0] addrR,
  input  logic [DATA_W-1:0] wrDataR,
  output logic [DATA_W-1:0] rdDataR,
  output logic              rdDriveR,
  output logic              busyRN,
  input  logic              busyInRN
);
  logic [NUM_PORTS-1:0][ADDR_W-1:0] addrV;
  logic [NUM_PORTS-1:0][DATA_W-1:0] wrV;
  logic [NUM_PORTS-1:0][DATA_W-1:0] rdV;
  logic [NUM_PORTS-1:0]             driveV;
  logic [NUM_PORTS-1:0]             busyV;
  dpStrobes_t                       strobes;

  assign addrV = {addrR, addrL};
  assign wrV   = {wrDataR, wrDataL};

  dpram_arb_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .masterMode (masterMode),
    .ceN        ({ceRN, ceLN}),
    .rwN        ({rwRN, rwLN}),
    .oeN        ({oeRN, oeLN}),
    .addr       (addrV),
    .extBusyN   ({busyInRN, busyInLN}),
    .strobes    (strobes),
    .busyN      (busyV)
  );

  dpram_arb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .addr    (addrV),
    .wrData  (wrV),
    .rdData  (rdV),
    .rdDrive (driveV)
  );

  assign rdDataL  = rdV[PORT_L];
  assign rdDataR  = rdV[PORT_R];
  assign rdDriveL = driveV[PORT_L];
  assign rdDriveR = driveV[PORT_R];
  assign busyLN   = busyV[PORT_L];
  assign busyRN   = busyV[PORT_R];
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              masterMode,
  input logic              ceLN,
  input logic              rwLN,
  input logic              oeLN,
  input logic [ADDR_W-1:0] addrL,
  input logic              ceRN,
  input logic              rwRN,
  input logic              oeRN,
  input logic [ADDR_W-1:0] addrR,
  input logic [DATA_W-1:0] rdDataL,
  input logic [DATA_W-1:0] rdDataR,
  input logic              rdDriveL,
  input logic              rdDriveR,
  input logic              busyLN,
  input logic              busyRN
);
  assert_busy_on_collision_R3: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && !ceLN && !ceRN && addrL == addrR) |=> (busyLN != busyRN));

  assert_busy_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(!busyLN && !busyRN));

  assert_busy_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(masterMode && !ceLN && !ceRN && addrL == addrR) |=> (busyLN && busyRN));

  assert_slave_released_R9: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |=> (busyLN && busyRN));

  assert_left_no_drive_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ceLN || !rwLN || oeLN) |=> !rdDriveL);

  assert_right_no_drive_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ceRN || !rwRN || oeRN) |=> !rdDriveR);

  assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!rdDriveL |-> rdDataL == '0) and (!rdDriveR |-> rdDataR == '0));
endmodule

bind dpram_arb_top dpram_arb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .masterMode(masterMode),
  .ceLN(ceLN), .rwLN(rwLN), .oeLN(oeLN), .addrL(addrL),
  .ceRN(ceRN), .rwRN(rwRN), .oeRN(oeRN), .addrR(addrR),
  .rdDataL(rdDataL), .rdDataR(rdDataR),
  .rdDriveL(rdDriveL), .rdDriveR(rdDriveR),
  .busyLN(busyLN), .busyRN(busyRN)
);

// File: tb/dpram_arb_tb.sv
module dpram_arb_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterMode = 1'b1;
  logic ceLN = 1'b1, rwLN = 1'b1, oeLN = 1'b1, busyInLN = 1'b1;
  logic ceRN = 1'b1, rwRN = 1'b1, oeRN = 1'b1, busyInRN = 1'b1;
  logic [AW-1:0] addrL = '0, addrR = '0;
  logic [DW-1:0] wrDataL = '0, wrDataR = '0;
  logic [DW-1:0] rdDataL, rdDataR;
  logic rdDriveL, rdDriveR, busyLN, busyRN;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpram_arb_top #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .ceLN(ceLN), .rwLN(rwLN), .oeLN(oeLN), .addrL(addrL), .wrDataL(wrDataL),
    .rdDataL(rdDataL), .rdDriveL(rdDriveL), .busyLN(busyLN), .busyInLN(busyInLN),
    .ceRN(ceRN), .rwRN(rwRN), .oeRN(oeRN), .addrR(addrR), .wrDataR(wrDataR),
    .rdDataR(rdDataR), .rdDriveR(rdDriveR), .busyRN(busyRN), .busyInRN(busyInRN)
  );

  // ---------------- behavioural reference ----------------
  logic [DW-1:0] refMem [int];
  bit eBusyL = 1, eBusyR = 1, eEnL = 0, eEnR = 0, eKnL = 0, eKnR = 0;
  logic [DW-1:0] eDL = '0, eDR = '0;
  bit pEnL = 0, pEnR = 0, pWinR = 0;
  int pAL = 0, pAR = 0;

  always @(posedge clk) begin
    bit coll, hL, hR, wR, lL, lR, bL, bR;
    if (!rstN) begin
      eBusyL = 1; eBusyR = 1; eEnL = 0; eEnR = 0;
      pEnL = 0; pEnR = 0; pAL = 0; pAR = 0; pWinR = 0;
    end else begin
      coll = !ceLN && !ceRN && (addrL == addrR);
      hL = pEnL && (pAL == int'(addrL));
      hR = pEnR && (pAR == int'(addrR));
      wR = coll && hR && (!hL || pWinR);
      lL = coll && wR;
      lR = coll && !wR;
      if (masterMode) begin bL = lL; bR = lR; end
      else begin bL = !busyInLN; bR = !busyInRN; end
      eEnL = !ceLN && rwLN && !oeLN;
      eEnR = !ceRN && rwRN && !oeRN;
      if (eEnL) begin eKnL = refMem.exists(int'(addrL)); if (eKnL) eDL = refMem[int'(addrL)]; end
      if (eEnR) begin eKnR = refMem.exists(int'(addrR)); if (eKnR) eDR = refMem[int'(addrR)]; end
      if (!ceLN && !rwLN && !bL) refMem[int'(addrL)] = wrDataL;
      if (!ceRN && !rwRN && !bR) refMem[int'(addrR)] = wrDataR;
      eBusyL = masterMode ? !lL : 1'b1;
      eBusyR = masterMode ? !lR : 1'b1;
      pEnL = !ceLN; pEnR = !ceRN;
      pAL = int'(addrL); pAR = int'(addrR);
      pWinR = wR;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R3 busyL", int'(busyLN), int'(eBusyL));
    chk("R3 busyR", int'(busyRN), int'(eBusyR));
    chk("R2 driveL", int'(rdDriveL), int'(eEnL));
    chk("R2 driveR", int'(rdDriveR), int'(eEnR));
    if (!eEnL) chk("R2 dataL", int'(rdDataL), 0);
    else if (eKnL) chk("R1 dataL", int'(rdDataL), int'(eDL));
    if (!eEnR) chk("R2 dataR", int'(rdDataR), 0);
    else if (eKnR) chk("R1 dataR", int'(rdDataR), int'(eDR));
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    compareAll();
  endtask

  task automatic idle();
    ceLN = 1; rwLN = 1; oeLN = 1; ceRN = 1; rwRN = 1; oeRN = 1;
    busyInLN = 1; busyInRN = 1;
  endtask

  task automatic portL(input bit rd, input int a, input int d);
    ceLN = 0; rwLN = rd; oeLN = 0; addrL = AW'(a); wrDataL = DW'(d);
  endtask

  task automatic portR(input bit rd, input int a, input int d);
    ceRN = 0; rwRN = rd; oeRN = 0; addrR = AW'(a); wrDataR = DW'(d);
  endtask

  function automatic int fillVal(input int a);
    return (a * 37 + 5) & 9'h1ff;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) step();
    chk("R11 busyL", int'(busyLN), 1);
    chk("R11 busyR", int'(busyRN), 1);
    chk("R11 driveL", int'(rdDriveL), 0);
    rstN = 1;
    step();
    chk("R11 driveR after", int'(rdDriveR), 0);

    for (int a = 0; a < 16; a++) begin
      portL(0, a, fillVal(a));
      portR(0, a + 16, fillVal(a + 16));
      step();
    end
    idle(); step();

    portL(1, 3, 0); step();
    chk("R1 read back", int'(rdDataL), fillVal(3));
    chk("R1 drive", int'(rdDriveL), 1);
    portL(1, 3, 0); oeLN = 1; step();
    chk("R2 oe off drive", int'(rdDriveL), 0);
    chk("R2 oe off data", int'(rdDataL), 0);

    portL(1, 5, 0); portR(1, 5, 0); step();
    chk("R4 right busy", int'(busyRN), 0);
    chk("R4 left free", int'(busyLN), 1);
    chk("R7 busy read", int'(rdDataR), fillVal(5));

    portL(1, 5, 0); portR(1, 6, 0); step();
    chk("R8 release", int'(busyRN), 1);

    idle(); step();
    portL(0, 6, 9'h0aa); portR(0, 6, 9'h155); step();
    chk("R6 right loses", int'(busyRN), 0);
    idle(); step();
    portL(1, 6, 0); step();
    chk("R6 kept left", int'(rdDataL), 9'h0aa);

    idle(); step();
    portR(1, 8, 0); step();
    portL(0, 8, 9'h011); portR(1, 8, 0); step();
    chk("R5 left busy", int'(busyLN), 0);
    chk("R5 right free", int'(busyRN), 1);
    chk("R5 right data", int'(rdDataR), fillVal(8));
    portL(0, 8, 9'h022); portR(1, 8, 0); step();
    chk("R5 priority kept", int'(busyLN), 0);
    idle(); step();
    portL(1, 8, 0); step();
    chk("R6 blocked write", int'(rdDataL), fillVal(8));

    idle(); step();
    portL(0, 9, 9'h1f0); portR(1, 9, 0); step();
    chk("R10 old word", int'(rdDataR), fillVal(9));
    idle(); portR(1, 9, 0); step();
    chk("R10 new word", int'(rdDataR), 9'h1f0);

    idle(); portL(1, 10, 0); addrR = AW'(10); step();
    chk("R3 one enable", int'(busyLN), 1);
    chk("R3 one enable r", int'(busyRN), 1);

    idle(); busyInLN = 0; busyInRN = 0; portL(0, 13, 9'h0e1); step();
    idle(); portL(1, 13, 0); step();
    chk("R9 inputs ignored in master", int'(rdDataL), 9'h0e1);

    idle(); masterMode = 0; step();
    portL(0, 11, 9'h0c3); portR(0, 11, 9'h13c); busyInRN = 0; step();
    chk("R9 slave busyL", int'(busyLN), 1);
    chk("R9 slave busyR", int'(busyRN), 1);
    idle(); portL(1, 11, 0); step();
    chk("R9 gated right", int'(rdDataL), 9'h0c3);
    idle(); busyInLN = 0; portL(0, 12, 9'h0ff); step();
    idle(); portL(1, 12, 0); step();
    chk("R9 gated left", int'(rdDataL), fillVal(12));
    idle(); portL(0, 14, 9'h033); portR(0, 14, 9'h0cc); step();
    idle(); portL(1, 14, 0); step();
    chk("R9 right prevails", int'(rdDataL), 9'h0cc);

    for (int seg = 0; seg < 3; seg++) begin
      idle(); masterMode = (seg != 1); step();
      for (int n = 0; n < 1500; n++) begin
        int rng;
        rng = (n % 3 == 0) ? 3 : 31;
        ceLN = ($urandom_range(0, 4) == 0); rwLN = $urandom_range(0, 1);
        oeLN = ($urandom_range(0, 5) == 0);
        addrL = AW'($urandom_range(0, rng)); wrDataL = DW'($urandom);
        ceRN = ($urandom_range(0, 4) == 0); rwRN = $urandom_range(0, 1);
        oeRN = ($urandom_range(0, 5) == 0);
        addrR = AW'($urandom_range(0, rng)); wrDataR = DW'($urandom);
        busyInLN = $urandom_range(0, 1); busyInRN = $urandom_range(0, 1);
        step();
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule